// File: doc/BRIEF.md
# Front Panel Data Register

An operator-editable data register that sits beside the data bus of a small microprocessor system and backs a front panel. While the processor is halted, the operator can pull the current data bus value into the register, then flip individual bits up or down with a momentary set or clear control for each bit. Editing never reaches the bus. Only a deposit command turns on the bus driver, which presents the held value so that memory can be written with it.

While the processor runs, the register stays off the bus and clears itself. Its indicator outputs then follow live data bus traffic instead of the stored value. All command inputs are taken as already debounced and synchronous to the block clock. Command sequencing, the address path and write strobe timing belong to other blocks. The bus driver is modelled as a value output paired with a separate output enable, so that a tri-state pad can be placed at the chip boundary.

Top module: `fpdr_data_reg`

## Requirements
- R1: A synchronous active-high reset clears every held bit, so the indicators read 0 while halted and the bus enable is 0.
- R2: While halted, a load command makes the held value equal the data bus value sampled at that clock edge; the indicators and bus value output show it from the next cycle.
- R3: When load is asserted in the same cycle as any per-bit set or clear, load wins and the held value equals the bus value.
- R4: While halted and not loading, a set pulse on bit i makes bit i equal to 1 at the next edge and leaves every other bit unchanged.
- R5: While halted and not loading, a clear pulse on bit i makes bit i equal to 0 and leaves every other bit unchanged; when set and clear are both asserted on one bit, that bit becomes 0.
- R6: The bus enable output is 1 exactly when deposit is 1 and run is 0, and while enabled the bus value output equals the held value.
- R7: Load, set and clear activity with deposit low never raises the bus enable.
- R8: Any clock edge with run high leaves the held value at 0.
- R9: The indicators equal the live data bus input while run is high and equal the held value while run is low.
- R10: Load, deposit, set and clear have no effect while run is high: the bus enable stays 0 and, once run falls, the held value reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 while the processor is running, 0 while halted |
| load_i | input | 1 | Capture the data bus into the register |
| deposit_i | input | 1 | Drive the held value onto the data bus |
| bit_set_i | input | WIDTH | Per-bit set commands |
| bit_clr_i | input | WIDTH | Per-bit clear commands |
| bus_data_i | input | WIDTH | Live data bus value |
| bus_out_o | output | WIDTH | Value presented to the bus driver |
| bus_oe_o | output | 1 | Bus driver enable |
| lamp_o | output | WIDTH | Indicator outputs |

## Verification
The assertions take for granted that every command input is clean and sampled on the block clock, with no glitches inside a cycle, and that reset is held high from time zero until the first few edges. They impose no mutual exclusion between load, set, clear and deposit, so the priority rules are checked against every overlap. The stimulus changes inputs only on the falling clock edge, holds reset for two cycles at start, and sweeps all 256 bus values for capture and live mirroring as well as every bit position for set, clear and their overlap.

// File: rtl/fpdr_pkg.sv
package fpdr_pkg;

   // Action applied to one storage bit at the next clock edge.
   typedef enum logic [2:0] {
      ACT_HOLD = 3'd0,
      ACT_ZERO = 3'd1,
      ACT_LOAD = 3'd2,
      ACT_SET  = 3'd3,
      ACT_CLR  = 3'd4
   } cell_act_e;

   // Priority: running > load > clear > set > hold.
   function automatic cell_act_e decode_act(input logic run,
                                            input logic load,
                                            input logic set,
                                            input logic clr);
      cell_act_e a;
      if (run)       a = ACT_ZERO;
      else if (load) a = ACT_LOAD;
      else if (clr)  a = ACT_CLR;
      else if (set)  a = ACT_SET;
      else           a = ACT_HOLD;
      return a;
   endfunction

endpackage

// File: rtl/fpdr_bit_cell.sv
module fpdr_bit_cell
   import fpdr_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  cell_act_e act_i,
   input  logic      d_i,
   output logic      q_o
);

   logic q_next;

   always_comb begin
      unique case (act_i)
         ACT_ZERO: q_next = 1'b0;
         ACT_LOAD: q_next = d_i;
         ACT_SET:  q_next = 1'b1;
         ACT_CLR:  q_next = 1'b0;
         default:  q_next = q_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q_o <= 1'b0;
      else     q_o <= q_next;
   end

endmodule

// File: rtl/fpdr_bus_drive.sv
module fpdr_bus_drive #(
   parameter int WIDTH = 8
) (
   input  logic             deposit_i,
   input  logic             run_i,
   input  logic [WIDTH-1:0] held_i,
   output logic [WIDTH-1:0] out_o,
   output logic             oe_o
);

   assign oe_o  = deposit_i & ~run_i;
   assign out_o = held_i;

endmodule

// File: rtl/fpdr_lamp_sel.sv
module fpdr_lamp_sel #(
   parameter int WIDTH = 8
) (
   input  logic             run_i,
   input  logic [WIDTH-1:0] bus_i,
   input  logic [WIDTH-1:0] held_i,
   output logic [WIDTH-1:0] lamp_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_lamp
      assign lamp_o[i] = run_i ? bus_i[i] : held_i[i];
   end

endmodule

// File: rtl/fpdr_data_reg.sv
module fpdr_data_reg
   import fpdr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run_i,
   input  logic             load_i,
   input  logic             deposit_i,
   input  logic [WIDTH-1:0] bit_set_i,
   input  logic [WIDTH-1:0] bit_clr_i,
   input  logic [WIDTH-1:0] bus_data_i,
   output logic [WIDTH-1:0] bus_out_o,
   output logic             bus_oe_o,
   output logic [WIDTH-1:0] lamp_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("fpdr_data_reg: WIDTH must be in 1..64");
   end

   logic [MSB:0] held;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      cell_act_e act;
      assign act = decode_act(run_i, load_i, bit_set_i[i], bit_clr_i[i]);

      fpdr_bit_cell u_cell (
         .clk   (clk),
         .rst   (rst),
         .act_i (act),
         .d_i   (bus_data_i[i]),
         .q_o   (held[i])
      );

      AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
         (!run_i && load_i) |=> (held[i] == $past(bus_data_i[i])))
         else $error("load capture bit %0d", i); // R2

      AST_SET_ONE: assert property (@(posedge clk) disable iff (rst)
         (!run_i && !load_i && bit_set_i[i] && !bit_clr_i[i]) |=> held[i])
         else $error("set bit %0d", i); // R4

      AST_CLR_ONE: assert property (@(posedge clk) disable iff (rst)
         (!run_i && !load_i && bit_clr_i[i]) |=> !held[i])
         else $error("clear bit %0d", i); // R5

      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
         (!run_i && !load_i && !bit_set_i[i] && !bit_clr_i[i]) |=> $stable(held[i]))
         else $error("idle hold bit %0d", i); // R4
   end

   fpdr_bus_drive #(.WIDTH(WIDTH)) u_drive (
      .deposit_i (deposit_i),
      .run_i     (run_i),
      .held_i    (held),
      .out_o     (bus_out_o),
      .oe_o      (bus_oe_o)
   );

   fpdr_lamp_sel #(.WIDTH(WIDTH)) u_lamp (
      .run_i  (run_i),
      .bus_i  (bus_data_i),
      .held_i (held),
      .lamp_o (lamp_o)
   );

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (held == '0))
      else $error("reset did not clear"); // R1

   AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
      run_i |=> (held == '0))
      else $error("run did not clear"); // R8

   AST_NO_DRIVE_RUN: assert property (@(posedge clk) disable iff (rst)
      run_i |-> !bus_oe_o)
      else $error("bus driven while running"); // R10

   AST_EDIT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      !deposit_i |-> !bus_oe_o)
      else $error("bus driven without deposit"); // R7

   AST_DRIVE_VALUE: assert property (@(posedge clk) disable iff (rst)
      bus_oe_o |-> (bus_out_o == lamp_o))
      else $error("driven value differs from held"); // R6

   AST_LAMP_LIVE: assert property (@(posedge clk) disable iff (rst)
      run_i |-> (lamp_o == bus_data_i))
      else $error("lamps not live while running"); // R9

   AST_LAMP_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!run_i && $past(!run_i) && !load_i && $past(!load_i) &&
       bit_set_i == '0 && $past(bit_set_i) == '0 &&
       bit_clr_i == '0 && $past(bit_clr_i) == '0) |-> $stable(lamp_o))
      else $error("lamps moved while idle and halted"); // R9

endmodule

// File: tb/fpdr_data_reg_tb.sv
`timescale 1ns/100ps
module fpdr_data_reg_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic       run_i, load_i, deposit_i;
   logic [7:0] bit_set_i, bit_clr_i, bus_data_i;
   logic [7:0] bus_out_o, lamp_o;
   logic       bus_oe_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [7:0] exp;

   always #2.5 clk = ~clk;

   fpdr_data_reg #(.WIDTH(8)) u_dut (
      .clk(clk), .rst(rst), .run_i(run_i), .load_i(load_i),
      .deposit_i(deposit_i), .bit_set_i(bit_set_i), .bit_clr_i(bit_clr_i),
      .bus_data_i(bus_data_i), .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o),
      .lamp_o(lamp_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] want);
      checks++;
      if (act !== want) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, want);
      end
   endtask

   task automatic idle();
      load_i = 0; deposit_i = 0; bit_set_i = '0; bit_clr_i = '0;
   endtask

   // Drive a load of v and wait one edge (inputs change on falling edges).
   task automatic do_load(input logic [7:0] v);
      bus_data_i = v; load_i = 1;
      @(negedge clk);
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1; run_i = 0; bus_data_i = '0; idle();
      @(negedge clk); @(negedge clk);
      chk("R1 reset lamps", lamp_o, 8'h00);
      chk("R1 reset oe", {7'd0, bus_oe_o}, 8'h00);
      rst = 0;

      // R2 capture every bus value; R7 no drive while loading without deposit
      for (int v = 0; v < 256; v++) begin
         bus_data_i = v[7:0]; load_i = 1;
         #1 chk("R7 oe during load", {7'd0, bus_oe_o}, 8'h00);
         @(negedge clk); idle();
         bus_data_i = ~v[7:0];
         #1;
         chk("R2 lamps after load", lamp_o, v[7:0]);
         chk("R2 bus value after load", bus_out_o, v[7:0]);
      end

      // R3 load beats set/clear
      for (int k = 0; k < 16; k++) begin
         exp = 8'(k * 17 + 3);
         bus_data_i = exp; load_i = 1; bit_set_i = ~exp; bit_clr_i = exp;
         @(negedge clk); idle();
         chk("R3 load priority", lamp_o, exp);
      end

      // R4 set single bits from two backgrounds
      for (int i = 0; i < 8; i++) begin
         do_load(8'h00);
         bit_set_i = 8'(1 << i);
         #1 chk("R7 oe during set", {7'd0, bus_oe_o}, 8'h00);
         @(negedge clk); idle();
         chk("R4 set from zero", lamp_o, 8'(1 << i));
         do_load(8'hA5);
         bit_set_i = 8'(1 << i);
         @(negedge clk); idle();
         chk("R4 set from A5", lamp_o, 8'hA5 | 8'(1 << i));
      end

      // R5 clear single bits; set+clear on one bit clears
      for (int i = 0; i < 8; i++) begin
         do_load(8'hFF);
         bit_clr_i = 8'(1 << i);
         @(negedge clk); idle();
         chk("R5 clear from FF", lamp_o, ~8'(1 << i));
         do_load(8'h00);
         bit_clr_i = 8'(1 << i); bit_set_i = 8'(1 << i);
         @(negedge clk); idle();
         chk("R5 set and clear together", lamp_o, 8'h00);
         do_load(8'h5A);
         bit_clr_i = 8'(1 << i); bit_set_i = 8'(1 << i);
         @(negedge clk); idle();
         chk("R5 both from 5A", lamp_o, 8'h5A & ~8'(1 << i));
      end

      // R6 deposit/run combinations
      do_load(8'h3C);
      for (int c = 0; c < 4; c++) begin
         deposit_i = c[0]; run_i = c[1];
         #1;
         chk("R6 oe truth", {7'd0, bus_oe_o}, {7'd0, (c == 1)});
         if (c == 1) chk("R6 driven value", bus_out_o, 8'h3C);
         deposit_i = 0; run_i = 0;
         #1;
      end
      chk("R6 value kept after deposit probes", lamp_o, 8'h3C);

      // R8 run clears; R9 lamps live while running
      do_load(8'h77);
      run_i = 1;
      for (int v = 0; v < 256; v++) begin
         bus_data_i = v[7:0];
         #1 chk("R9 lamps live", lamp_o, v[7:0]);
         @(negedge clk);
      end
      run_i = 0; bus_data_i = 8'h99;
      #1 chk("R8 cleared after run", lamp_o, 8'h00);
      chk("R9 lamps held while halted", lamp_o, 8'h00);

      // R10 commands ignored while running
      do_load(8'h12);
      run_i = 1; load_i = 1; deposit_i = 1; bus_data_i = 8'hAA; bit_set_i = 8'hFF;
      #1 chk("R10 no drive while running", {7'd0, bus_oe_o}, 8'h00);
      @(negedge clk); @(negedge clk);
      idle(); run_i = 0;
      #1 chk("R10 load/set ignored while running", lamp_o, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule